// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked request source and an external asynchronous static RAM of 512K locations by 8 bits. It takes one read or write at a time over a valid/ready handshake. It then turns that request into a sequence on the memory's active-low chip select, write enable and output enable. The sequence is timed by counting system clock cycles. The data pins are tri-state, so the controller presents them as a separate output value, an input value and a drive enable for the pad logic above it.

Every phase length is set by a nanosecond limit of the memory. Each limit is divided by the clock period parameter and rounded up to whole cycles, with a floor of one cycle. A write is strobed by write enable by default. A build parameter makes chip select the strobe instead, with write enable held low around the pulse. After each transaction the controller waits out the memory's output float time before it accepts another request, so its own data driver can never collide with the memory's.

Top module: `sram_async_ctrl`

## Requirements
- R1: During reset and whenever `req_ready` is high, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1 and `mem_dq_oe` is 0; `req_ready` is 1 in the first cycle after reset is released.
- R2: Phase lengths are ceil(ns / `CLK_NS`), at least 1. With the defaults (10 ns clock, 70 ns access, 65 ns write) a read completes 7 clock edges after the accepting edge and a write 9 edges after it (1 setup + 7 strobe + 1 end cycle).
- R3: A read holds `mem_cs_n`=0, `mem_oe_n`=0, `mem_we_n`=1 for the whole access, samples `mem_dq_i` on the last access edge, and presents it on `rsp_rdata` with a one-cycle `rsp_valid` pulse in the following cycle.
- R4: With `CS_STROBE`=0, a write lowers chip select one cycle before write enable, pulses write enable low, raises it while chip select is still low, and keeps data driven through that end cycle; output enable stays high.
- R5: With `CS_STROBE`=1, write enable goes low one cycle before chip select, chip select forms the pulse, and chip select rises while write enable is still low with data still driven.
- R6: Each write meets: strobe low ≥ 50 ns, chip select low ≥ 60 ns, address stable ≥ 65 ns and data stable ≥ 40 ns before the end of the write, and zero hold after it.
- R7: After any transaction `req_ready` stays low for ceil(`T_HZ_NS`/`CLK_NS`) cycles (3 by default) after the `rsp_valid` edge. The data driver is never enabled while output enable is low, nor within 30 ns of the memory ceasing to drive.
- R8: Only one transaction is in flight: `req_ready` is low while the memory is selected or being written, and a request held during that time is not performed.
- R9: The memory address is unchanged while chip select stays low, and write data is unchanged while the driver stays enabled.
- R10: A value written to an address is returned by a later read of that address, and the latest write to an address wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to accept |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Memory address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_rdata | output | DW | Read data, valid with the done pulse of a read |
| mem_addr | output | AW | Address pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | DW | Value for the data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_i | input | DW | Value seen on the data pins |

## Verification
Both strobe variants run side by side on the same request stream, each with its own behavioural memory. The memory flags any access, pulse, setup, hold or bus-contention breach, and it returns inverted data when it is sampled too early. Walking-one addresses and the all-zero and all-one addresses separate each address line. Pseudo-random addresses carry hashed data, so misrouted bits or stale reads show up. Writes followed at once by reads of the same address exercise turnaround and overwrite. A request held while a write is in progress shows whether a second transaction can slip in.

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl #(
  parameter int AW        = 19,
  parameter int DW        = 8,
  parameter int CLK_NS    = 10,
  parameter int T_AA_NS   = 70,
  parameter int T_OE_NS   = 35,
  parameter int T_RC_NS   = 70,
  parameter int T_WP_NS   = 50,
  parameter int T_CW_NS   = 60,
  parameter int T_AW_NS   = 65,
  parameter int T_DW_NS   = 40,
  parameter int T_WC_NS   = 70,
  parameter int T_HZ_NS   = 30,
  parameter bit CS_STROBE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_RD  = cyc(mx(mx(T_AA_NS, T_OE_NS), T_RC_NS));
  localparam int N_WS  = mx(cyc(mx(mx(T_WP_NS, T_CW_NS), mx(T_AW_NS, T_DW_NS))),
                            cyc(T_WC_NS) - 2);
  localparam int N_TA  = cyc(T_HZ_NS);
  localparam int N_MAX = mx(mx(N_RD, N_WS), N_TA);
  localparam int CW    = $clog2(N_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WPRE, S_WSTB, S_WEND, S_TURN} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          if (req_we) state <= S_WPRE;
          else begin
            state <= S_RD;
            cnt   <= CW'(N_RD - 1);
          end
        end
        S_RD: if (cnt == '0) begin
          rdata_q <= mem_dq_i;
          done_q  <= 1'b1;
          state   <= S_TURN;
          cnt     <= CW'(N_TA - 1);
        end else cnt <= cnt - 1'b1;
        S_WPRE: begin
          state <= S_WSTB;
          cnt   <= CW'(N_WS - 1);
        end
        S_WSTB: if (cnt == '0) state <= S_WEND;
                else cnt <= cnt - 1'b1;
        S_WEND: begin
          done_q <= 1'b1;
          state  <= S_TURN;
          cnt    <= CW'(N_TA - 1);
        end
        S_TURN: if (cnt == '0) state <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic in_rd, in_wr, in_stb;
  assign in_rd  = (state == S_RD);
  assign in_stb = (state == S_WSTB);
  assign in_wr  = (state == S_WPRE) || in_stb || (state == S_WEND);

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = done_q;
  assign rsp_rdata = rdata_q;
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = in_wr;
  assign mem_oe_n  = !in_rd;
  assign mem_cs_n  = !(in_rd || (CS_STROBE ? in_stb : in_wr));
  assign mem_we_n  = !(CS_STROBE ? in_wr : in_stb);

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic [DW-1:0] mem_dq_o,
  input logic          mem_dq_oe
);

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3

  AST_OE_NOT_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe)); // R4

  AST_NO_DRIVE_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R7

  AST_DRIVE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mem_oe_n) |-> !mem_dq_oe); // R7

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R7

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n || !mem_we_n) |-> !req_ready); // R8

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R9

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o)); // R9

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe));

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_beh_model #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic [AW-1:0] a,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [DW-1:0] d_in,
  input  logic          d_en,
  output logic [DW-1:0] d_out,
  output int            viol
);
  logic [DW-1:0] mem [int];
  realtime t_a = 0, t_cs = 0, t_oe = 0, t_d = 0, t_ws = 0, t_off = -1000;
  bit wr_act = 0, drv = 0;

  initial viol = 0;

  always @(a) begin
    if (!cs_n && !we_n) begin viol++; $display("VIOL address moved in write"); end
    t_a = $realtime;
  end
  always @(d_in or d_en) begin
    if (!cs_n && !we_n) begin viol++; $display("VIOL data moved in write"); end
    t_d = $realtime;
  end
  always @(negedge cs_n) t_cs = $realtime;
  always @(negedge oe_n) t_oe = $realtime;
  always @(posedge d_en)
    if (drv || ($realtime - t_off) < 30.0) begin viol++; $display("VIOL bus contention"); end

  always @(cs_n or we_n or oe_n) begin
    bit act, dn;
    act = !cs_n && !we_n;
    dn  = !cs_n && !oe_n && we_n;
    if (act && !wr_act) t_ws = $realtime;
    if (!act && wr_act) begin
      if ($realtime - t_ws < 50.0) begin viol++; $display("VIOL strobe width"); end
      if ($realtime - t_cs < 60.0) begin viol++; $display("VIOL select width"); end
      if ($realtime - t_a  < 65.0) begin viol++; $display("VIOL address setup"); end
      if ($realtime - t_d  < 40.0) begin viol++; $display("VIOL data setup"); end
      if (!d_en) begin viol++; $display("VIOL data not driven"); end
      mem[int'(a)] = d_in;
    end
    if (dn && d_en) begin viol++; $display("VIOL drive while output on"); end
    if (drv && !dn) t_off = $realtime;
    wr_act = act;
    drv = dn;
  end

  initial begin
    d_out = '0;
    #0.5;
    forever begin
      logic [DW-1:0] v;
      realtime ta;
      v  = mem.exists(int'(a)) ? mem[int'(a)] : '0;
      ta = (t_a > t_cs) ? t_a : t_cs;
      if (drv && ($realtime - ta) > 69.0 && ($realtime - t_oe) > 34.0) d_out = v;
      else d_out = ~v;
      #1;
    end
  end
endmodule

module sram_async_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int NA = 45;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          rst_n = 1'b0, req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;

  logic          rdy_w, rsp_w, cs_w, we_w, oe_w, dqoe_w;
  logic [DW-1:0] rd_w, dqo_w, dqi_w;
  logic [AW-1:0] ad_w;
  logic          rdy_c, rsp_c, cs_c, we_c, oe_c, dqoe_c;
  logic [DW-1:0] rd_c, dqo_c, dqi_c;
  logic [AW-1:0] ad_c;
  int            viol_w, viol_c;

  sram_async_ctrl #(.AW(AW), .DW(DW), .CLK_NS(CLK_PERIOD), .CS_STROBE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_w),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_w), .rsp_rdata(rd_w), .mem_addr(ad_w), .mem_cs_n(cs_w),
    .mem_we_n(we_w), .mem_oe_n(oe_w), .mem_dq_o(dqo_w), .mem_dq_oe(dqoe_w),
    .mem_dq_i(dqi_w));

  sram_async_ctrl #(.AW(AW), .DW(DW), .CLK_NS(CLK_PERIOD), .CS_STROBE(1'b1)) dut_cs_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_c),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_c), .rsp_rdata(rd_c), .mem_addr(ad_c), .mem_cs_n(cs_c),
    .mem_we_n(we_c), .mem_oe_n(oe_c), .mem_dq_o(dqo_c), .mem_dq_oe(dqoe_c),
    .mem_dq_i(dqi_c));

  sram_beh_model #(.AW(AW), .DW(DW)) m_we (.a(ad_w), .cs_n(cs_w), .we_n(we_w),
    .oe_n(oe_w), .d_in(dqo_w), .d_en(dqoe_w), .d_out(dqi_w), .viol(viol_w));
  sram_beh_model #(.AW(AW), .DW(DW)) m_cs (.a(ad_c), .cs_n(cs_c), .we_n(we_c),
    .oe_n(oe_c), .d_in(dqo_c), .d_en(dqoe_c), .d_out(dqi_c), .viol(viol_c));

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input logic [7:0] salt);
    logic [31:0] h;
    h = 32'(a) * 32'h9E3779B1 + 32'(salt) * 32'h01000193;
    return h[31:24];
  endfunction

  task automatic xfer(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output logic [DW-1:0] rw, output logic [DW-1:0] rc,
                      output int lat, output int gap, output bit same, output bit pulse1);
    @(negedge clk);
    while (!(rdy_w && rdy_c)) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_w && lat < 60) begin @(negedge clk); lat++; end
    same = (rsp_c == rsp_w);
    rw = rd_w; rc = rd_c;
    gap = 0; pulse1 = 1'b1;
    while (!rdy_w && gap < 60) begin
      @(negedge clk); gap++;
      if (rsp_w || rsp_c) pulse1 = 1'b0;
    end
  endtask

  logic [AW-1:0] al [NA];

  initial begin
    logic [DW-1:0] rw, rc;
    int lat, gap;
    bit same, p1;
    logic [31:0] lcg;

    al[0] = '0;
    al[1] = '1;
    for (int i = 0; i < AW; i++) al[2 + i] = AW'(1) << i;
    lcg = 32'h1234_5678;
    for (int i = 2 + AW; i < NA; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      al[i] = lcg[AW+5:6];
    end

    repeat (3) @(negedge clk);
    chk(cs_w && we_w && oe_w && !dqoe_w && cs_c && we_c && oe_c && !dqoe_c,
        "R1 bus idle in reset", {cs_w, we_w, oe_w, dqoe_w}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy_w && rdy_c, "R1 ready after reset", {rdy_w, rdy_c}, 2'b11);
    chk(cs_w && we_w && oe_w && !dqoe_w, "R1 bus idle after reset",
        {cs_w, we_w, oe_w, dqoe_w}, 4'b1110);

    for (int i = 0; i < NA; i++) begin
      xfer(1'b1, al[i], pat(al[i], 8'd0), rw, rc, lat, gap, same, p1);
      chk(lat == 9, "R2 R4 R5 write latency", lat, 9);
      chk(same, "R5 strobe variants finish together", same, 1);
      chk(gap == 3, "R7 turnaround after write", gap, 3);
      chk(p1, "R3 done is one cycle", p1, 1);
    end

    for (int i = 0; i < NA; i++) begin
      xfer(1'b0, al[i], '0, rw, rc, lat, gap, same, p1);
      chk(lat == 7, "R2 R3 read latency", lat, 7);
      chk(rw == pat(al[i], 8'd0), "R10 R3 read data (write strobe)", rw, pat(al[i], 8'd0));
      chk(rc == pat(al[i], 8'd0), "R10 R5 read data (select strobe)", rc, pat(al[i], 8'd0));
      chk(gap == 3, "R7 turnaround after read", gap, 3);
    end

    for (int i = 20; i < 28; i++) begin
      xfer(1'b1, al[i], pat(al[i], 8'h3C), rw, rc, lat, gap, same, p1);
      xfer(1'b0, al[i], '0, rw, rc, lat, gap, same, p1);
      chk(rw == pat(al[i], 8'h3C) && rc == pat(al[i], 8'h3C),
          "R10 R7 overwrite then read", rw, pat(al[i], 8'h3C));
    end

    // R8: a request held while a write is busy must not be carried out
    @(negedge clk);
    while (!rdy_w) @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = al[1]; req_wdata = 8'h5A;
    @(negedge clk);
    req_addr = al[2]; req_wdata = ~pat(al[2], 8'd0);
    for (int k = 0; k < 6; k++) begin
      chk(!rdy_w && !rdy_c, "R8 not ready while busy", rdy_w, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    xfer(1'b0, al[2], '0, rw, rc, lat, gap, same, p1);
    chk(rw == pat(al[2], 8'd0) && rc == pat(al[2], 8'd0),
        "R8 held request not performed", rw, pat(al[2], 8'd0));
    xfer(1'b0, al[1], '0, rw, rc, lat, gap, same, p1);
    chk(rw == 8'h5A && rc == 8'h5A, "R10 accepted write landed", rw, 8'h5A);

    chk(viol_w == 0, "R4 R6 R7 R9 timing (write strobe)", viol_w, 0);
    chk(viol_c == 0, "R5 R6 R7 R9 timing (select strobe)", viol_c, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule